// File: doc/BRIEF.md
# Effective Address Calculation Unit

This block turns a decoded operand-addressing request into a 16-bit memory offset. When a request strobe is high, the caller gives it four things: a 3-bit mode code, two 2-bit register codes (one naming the base role, one naming the index role), a displacement with a width flag, and the current contents of the four pointer registers BX, BP, SI and DI. The block picks the operands the mode needs and sign-extends a short displacement. It then adds everything modulo 2^16. The result appears on a registered output one clock later.

The two modes whose operand is a constant or a register need no memory access. For those the block raises a separate no-memory flag and drives no offset. A request that puts a register in a role it may not fill is rejected: no output flag rises and the offset stays zero. Only BX and BP may act as base, and only SI and DI may act as index. Segment arithmetic and the decoding of instruction bytes belong to other blocks.

Top module: `eac_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first cycle after it, `ea_valid` and `ea_nomem` are 0 and `ea_offset` is 0.
- R2: Outputs change only in response to a request. When `req` is high in cycle N, the result is visible after the clock edge that ends cycle N, and it lasts exactly one clock. After a cycle with `req` low, `ea_valid` and `ea_nomem` are both 0.
- R3: Mode codes 0 (immediate) and 1 (register) produce `ea_nomem`=1, `ea_valid`=0 and `ea_offset`=0, whatever the register codes are.
- R4: Mode code 2 (direct) gives `ea_offset` = `disp`, all 16 bits, whatever `disp_wide` is.
- R5: Mode code 3 (register-indirect) gives the value of the register named by `base_sel`. Register codes are 0=BX, 1=BP, 2=SI, 3=DI, and all four codes are accepted in this mode.
- R6: Mode code 4 (based) gives the register named by `base_sel` plus the displacement. `index_sel` is ignored.
- R7: Mode code 5 (indexed) gives the register named by `index_sel` plus the displacement. `base_sel` is ignored.
- R8: Mode code 6 (based-indexed) gives the `base_sel` register plus the `index_sel` register. `disp` is ignored.
- R9: Mode code 7 (based-indexed with displacement) gives the `base_sel` register plus the `index_sel` register plus the displacement.
- R10: In modes 4, 5 and 7, `disp_wide`=1 uses all 16 bits of `disp`. `disp_wide`=0 uses `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` is ignored.
- R11: Every sum wraps modulo 65536. No overflow is signalled.
- R12: In modes 4, 6 and 7, a `base_sel` other than 0 or 1 is rejected. In modes 5, 6 and 7, an `index_sel` other than 2 or 3 is rejected. A rejected request gives `ea_valid`=0, `ea_nomem`=0 and `ea_offset`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per calculation |
| mode | input | 3 | Addressing-mode code (0..7) |
| base_sel | input | 2 | Register code for the base role, or the single register in indirect mode |
| index_sel | input | 2 | Register code for the index role |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit displacement |
| disp | input | 16 | Displacement, or direct address in mode 2 |
| reg_bx | input | 16 | Current BX value |
| reg_bp | input | 16 | Current BP value |
| reg_si | input | 16 | Current SI value |
| reg_di | input | 16 | Current DI value |
| ea_valid | output | 1 | One-clock pulse: `ea_offset` holds a memory offset |
| ea_nomem | output | 1 | One-clock pulse: the operand needs no memory access |
| ea_offset | output | 16 | Computed offset, 0 when `ea_valid` is low |

## Verification
The assertions check the timing and exclusivity rules on every cycle. No flag rises without a request in the previous cycle, and the two flags never rise together. Every rejected request ends with both flags low and a zero offset. Every short displacement carries its sign through the upper byte, and the immediate and register modes always yield the no-memory flag. Whether each mode chooses the right registers, and whether the wrapped sums are correct, is shown only by the bench. It sweeps every mode, every pair of register codes, both displacement widths, several displacement values and register sets chosen to force wrap-around, and compares each result with sums it computes itself.

// File: rtl/eac_pkg.sv
package eac_pkg;

  typedef enum logic [2:0] {
    AM_IMM      = 3'd0,
    AM_REG      = 3'd1,
    AM_DIRECT   = 3'd2,
    AM_INDIR    = 3'd3,
    AM_BASED    = 3'd4,
    AM_INDEXED  = 3'd5,
    AM_BIDX     = 3'd6,
    AM_BIDX_D   = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    RC_BX = 2'd0,
    RC_BP = 2'd1,
    RC_SI = 2'd2,
    RC_DI = 2'd3
  } rcode_e;

  typedef struct packed {
    logic use_base;
    logic use_index;
    logic use_disp;
    logic force_wide;
    logic nomem;
    logic need_base_role;
    logic need_index_role;
  } ctl_t;

  function automatic logic f_can_base(input rcode_e c);
    return (c == RC_BX) || (c == RC_BP);
  endfunction

  function automatic logic f_can_index(input rcode_e c);
    return (c == RC_SI) || (c == RC_DI);
  endfunction

  function automatic ctl_t f_decode(input amode_e m);
    ctl_t c;
    c = '0;
    case (m)
      AM_IMM, AM_REG: c.nomem = 1'b1;
      AM_DIRECT: begin
        c.use_disp   = 1'b1;
        c.force_wide = 1'b1;
      end
      AM_INDIR: c.use_base = 1'b1;
      AM_BASED: begin
        c.use_base       = 1'b1;
        c.use_disp       = 1'b1;
        c.need_base_role = 1'b1;
      end
      AM_INDEXED: begin
        c.use_index       = 1'b1;
        c.use_disp        = 1'b1;
        c.need_index_role = 1'b1;
      end
      AM_BIDX: begin
        c.use_base        = 1'b1;
        c.use_index       = 1'b1;
        c.need_base_role  = 1'b1;
        c.need_index_role = 1'b1;
      end
      default: begin
        c.use_base        = 1'b1;
        c.use_index       = 1'b1;
        c.use_disp        = 1'b1;
        c.need_base_role  = 1'b1;
        c.need_index_role = 1'b1;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/eac_reg_pick.sv
module eac_reg_pick #(
  parameter int AW = 16
) (
  input  eac_pkg::rcode_e  code,
  input  logic [AW-1:0]    reg_bx,
  input  logic [AW-1:0]    reg_bp,
  input  logic [AW-1:0]    reg_si,
  input  logic [AW-1:0]    reg_di,
  output logic [AW-1:0]    value
);
  import eac_pkg::*;

  always_comb begin
    case (code)
      RC_BX:   value = reg_bx;
      RC_BP:   value = reg_bp;
      RC_SI:   value = reg_si;
      default: value = reg_di;
    endcase
  end
endmodule

// File: rtl/eac_disp_ext.sv
module eac_disp_ext #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic [AW-1:0] disp,
  input  logic          wide,
  output logic [AW-1:0] ext
);
  localparam int PADW = AW - SW;

  function automatic logic [AW-1:0] f_sext(input logic [SW-1:0] s);
    return {{PADW{s[SW-1]}}, s};
  endfunction

  generate
    if (PADW > 0) begin : g_ext
      assign ext = wide ? disp : f_sext(disp[SW-1:0]);
    end else begin : g_pass
      assign ext = disp;
    end
  endgenerate
endmodule

// File: rtl/eac_sum3.sv
module eac_sum3 #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] c,
  output logic [AW-1:0] sum
);
  function automatic logic [AW-1:0] f_wrap_add3(input logic [AW-1:0] x,
                                                input logic [AW-1:0] y,
                                                input logic [AW-1:0] z);
    logic [AW+1:0] full;
    full = {2'b00, x} + {2'b00, y} + {2'b00, z};
    return full[AW-1:0];
  endfunction

  assign sum = f_wrap_add3(a, b, c);
endmodule

// File: rtl/eac_unit.sv
module eac_unit #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    index_sel,
  input  logic          disp_wide,
  input  logic [15:0]   disp,
  input  logic [15:0]   reg_bx,
  input  logic [15:0]   reg_bp,
  input  logic [15:0]   reg_si,
  input  logic [15:0]   reg_di,
  output logic          ea_valid,
  output logic          ea_nomem,
  output logic [15:0]   ea_offset
);
  import eac_pkg::*;

  localparam int UPW = AW - SW;

  amode_e         mode_e;
  rcode_e         base_c;
  rcode_e         index_c;
  ctl_t           ctl;
  logic [AW-1:0]  base_val;
  logic [AW-1:0]  index_val;
  logic [AW-1:0]  disp_x;
  logic [AW-1:0]  op_a;
  logic [AW-1:0]  op_b;
  logic [AW-1:0]  op_c;
  logic [AW-1:0]  sum_w;
  logic           wide_eff;
  logic           legal_w;
  logic           mem_hit_w;
  logic           nomem_hit_w;

  assign mode_e  = amode_e'(mode);
  assign base_c  = rcode_e'(base_sel);
  assign index_c = rcode_e'(index_sel);
  assign ctl     = f_decode(mode_e);

  // role legality
  assign legal_w = (!ctl.need_base_role  || f_can_base(base_c)) &&
                   (!ctl.need_index_role || f_can_index(index_c));

  assign mem_hit_w   = req && !ctl.nomem && legal_w;
  assign nomem_hit_w = req && ctl.nomem;

  eac_reg_pick #(.AW(AW)) u_pick_base (
    .code(base_c), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .value(base_val)
  );

  eac_reg_pick #(.AW(AW)) u_pick_index (
    .code(index_c), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .value(index_val)
  );

  assign wide_eff = disp_wide || ctl.force_wide;

  eac_disp_ext #(.AW(AW), .SW(SW)) u_disp (
    .disp(disp), .wide(wide_eff), .ext(disp_x)
  );

  assign op_a = ctl.use_base  ? base_val  : '0;
  assign op_b = ctl.use_index ? index_val : '0;
  assign op_c = ctl.use_disp  ? disp_x    : '0;

  eac_sum3 #(.AW(AW)) u_sum (
    .a(op_a), .b(op_b), .c(op_c), .sum(sum_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid  <= 1'b0;
      ea_nomem  <= 1'b0;
      ea_offset <= '0;
    end else begin
      ea_valid  <= mem_hit_w;
      ea_nomem  <= nomem_hit_w;
      ea_offset <= mem_hit_w ? sum_w : '0;
    end
  end

  // assertions
  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && ea_nomem));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!ea_valid && !ea_nomem));

  p_flag_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid || ea_nomem) |-> $past(req));

  p_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctl.nomem && !legal_w) |=> (!ea_valid && !ea_nomem && ea_offset == '0));

  p_nomem_modes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (mode_e == AM_IMM || mode_e == AM_REG)) |=> (ea_nomem && !ea_valid && ea_offset == '0));

  p_sext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_eff |-> (disp_x[AW-1:SW] == {UPW{disp[SW-1]}}));

  p_zero_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_valid |-> (ea_offset == '0));
endmodule

// File: tb/eac_unit_bench.sv
`timescale 1ns/1ps
module eac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  base_sel = '0;
  logic [1:0]  index_sel = '0;
  logic        disp_wide = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = '0;
  logic [15:0] reg_bp = '0;
  logic [15:0] reg_si = '0;
  logic [15:0] reg_di = '0;
  logic        ea_valid;
  logic        ea_nomem;
  logic [15:0] ea_offset;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eac_unit u_eac_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .base_sel(base_sel), .index_sel(index_sel), .disp_wide(disp_wide),
    .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
    .reg_di(reg_di), .ea_valid(ea_valid), .ea_nomem(ea_nomem),
    .ea_offset(ea_offset)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input logic v, input logic nm, input logic [15:0] off,
                       input string ctx);
    n_checks++;
    if (ea_valid !== v || ea_nomem !== nm || ea_offset !== off) begin
      n_fail++;
      $display("FAIL %s %s: got valid=%0b nomem=%0b off=%h, expected valid=%0b nomem=%0b off=%h",
               tag, ctx, ea_valid, ea_nomem, ea_offset, v, nm, off);
    end
  endtask

  function automatic int regval(input int code);
    case (code)
      0: return int'(reg_bx);
      1: return int'(reg_bp);
      2: return int'(reg_si);
      default: return int'(reg_di);
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] dvals [6];
    logic [15:0] rsets [3][4];
    dvals = '{16'h0000, 16'h007F, 16'h1280, 16'hA5FF, 16'hFF80, 16'h8001};
    rsets = '{'{16'h1234, 16'hFFF0, 16'h8000, 16'h0005},
              '{16'hFFFF, 16'h8001, 16'hFFFE, 16'h7FFF},
              '{16'h0000, 16'h0101, 16'h4000, 16'hC000}};

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0, 16'h0000, "during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 16'h0000, "after reset");

    for (int rs = 0; rs < 3; rs++) begin
      reg_bx = rsets[rs][0]; reg_bp = rsets[rs][1];
      reg_si = rsets[rs][2]; reg_di = rsets[rs][3];
      for (int m = 0; m < 8; m++)
        for (int bs = 0; bs < 4; bs++)
          for (int is = 0; is < 4; is++)
            for (int w = 0; w < 2; w++)
              for (int di = 0; di < 6; di++) begin
                int dx;
                int raw;
                bit ev, en, legal, usesd;
                logic [15:0] eo;
                string tag;
                logic [15:0] d;
                d = dvals[di];
                dx = (w == 1) ? int'(d) : (d[7] ? int'(d[7:0]) - 256 : int'(d[7:0]));
                ev = 1'b0; en = 1'b0; raw = 0; legal = 1'b1; usesd = 1'b0;
                case (m)
                  0, 1: begin en = 1'b1; tag = "R3"; end
                  2: begin raw = int'(d); tag = "R4"; end
                  3: begin raw = regval(bs); tag = "R5"; end
                  4: begin legal = (bs < 2); raw = regval(bs) + dx; usesd = 1'b1; tag = "R6"; end
                  5: begin legal = (is >= 2); raw = regval(is) + dx; usesd = 1'b1; tag = "R7"; end
                  6: begin legal = (bs < 2) && (is >= 2); raw = regval(bs) + regval(is); tag = "R8"; end
                  default: begin
                    legal = (bs < 2) && (is >= 2);
                    raw = regval(bs) + regval(is) + dx; usesd = 1'b1; tag = "R9";
                  end
                endcase
                if (m >= 2) begin
                  ev = legal;
                  if (!legal) tag = "R12";
                  else begin
                    if (usesd && w == 0) tag = {tag, "+R10"};
                    if (raw > 65535 || raw < 0) tag = {tag, "+R11"};
                  end
                end
                eo = ev ? 16'(((raw % 65536) + 65536) % 65536) : 16'h0000;

                mode = 3'(m); base_sel = 2'(bs); index_sel = 2'(is);
                disp_wide = w[0]; disp = d; req = 1'b1;
                @(negedge clk);
                req = 1'b0;
                check(tag, ev, en, eo,
                      $sformatf("set=%0d mode=%0d b=%0d i=%0d w=%0d d=%h", rs, m, bs, is, w, d));
                @(negedge clk);
                check("R2", 1'b0, 1'b0, 16'h0000, "one-clock pulse / idle");
              end
    end
    done = 1'b1;
    finish_run();
  end
endmodule